// File: doc/BRIEF.md
# Bandwidth slot allocation engine

This engine builds the contents of a 64-entry arbiter slot table from a set of per-client demands and streams the finished table to the arbiter's table write port. Software presents a requested slot count for each of the 14 clients, a mask of active clients and a budget of spare slots, then pulses a start strobe. The engine samples those inputs, fills an internal table in two passes, and writes one entry per cycle in ascending slot order. It pulses done once the last entry has been written.

The first pass walks the clients from index 0 upwards. A client that asks for n slots is spaced by 64/n (integer division). Its first entry goes into the earliest free slot, and every entry after that lands an interval further on, moving past any slot already taken. An active client that asks for nothing is given a single slot while the spare budget lasts. The second pass hands every slot still free to the active clients in round-robin order.

A combinational helper sits beside the engine. It turns a bandwidth figure into a slot count against a maximum bandwidth, and it tells software whether that count still fits next to the counts already presented.

Top module: `slot_plan_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_en` and `done` are 0.
- R2: Clients are placed in ascending index order. A client with a request n>0 uses interval 64/n (integer division). A cursor starts at slot 0. At an occupied slot the cursor moves on by 1. At a free slot the client is written there and the cursor moves on by the interval. The client stops once the cursor reaches 64. No slot is written twice in this pass.
- R3: An active client whose request is 0 gets one slot, with interval 64, only while the spare budget is above 0. Each such grant lowers the budget by 1. A zero-request client that is not active gets nothing in this pass.
- R4: After placement, the slots that are still free are filled in ascending slot order. Each one takes the next active client found by searching upwards from a round-robin cursor that wraps from 13 to 0. The cursor starts at client 0 and moves to the client after each one chosen.
- R5: When no client is active, the search gives up after one full wrap, and a free slot takes the client at the cursor. Free slots therefore receive 0, 1, 2, … in turn.
- R6: Each run emits exactly 64 writes in consecutive cycles. `wr_slot` counts 0 to 63 and `wr_client` is a 4-bit client index. `done` is high for exactly one cycle, the cycle after the write to slot 63.
- R7: `bw_slots` is 0 when `bw_value` is 0. Otherwise it is 64/(`bw_max`/`bw_value`) using integer division. When `bw_value` exceeds `bw_max` it is 127.
- R8: `admit_ok` is 1 exactly when the sum of all presented request counts plus `bw_slots` is at most 64.
- R9: A start pulse that arrives while a run is in progress is ignored. The inputs are sampled on the accepted start cycle, and later changes to them do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; honoured only when idle |
| req_counts | input | 98 | Requested slot count per client, 7 bits each, client c at bits [7c+6:7c] |
| active_mask | input | 14 | Bit c set marks client c active |
| spare_budget | input | 7 | Number of spare slots for zero-request active clients |
| bw_value | input | 32 | Bandwidth to convert into a slot count |
| bw_max | input | 32 | Maximum bandwidth of the memory region |
| bw_slots | output | 7 | Slot count converted from `bw_value` |
| admit_ok | output | 1 | Request of `bw_slots` fits beside the current counts |
| wr_en | output | 1 | Table write strobe |
| wr_slot | output | 6 | Slot index being written |
| wr_client | output | 4 | Client index written into the slot |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The engine is run with patterns that each isolate one rule:
- A single full-rate client shows that interval placement covers every slot.
- Two clients whose spacings collide show the move-on-by-one rule when a slot is taken.
- Zero-request clients with budgets of 0, 1 and 2 show exactly which of them receive a spare slot.
- A set of two active clients with no requests shows the round-robin alternation in the fill pass.
- An empty active mask shows the fallback where the cursor client is written.

Randomised request sets are compared slot by slot against an independent model of the algorithm. A start pulse with changed inputs part way through a run shows that the run in progress keeps its sampled inputs. A vector table covers the conversion helper at zero, exact-fit, over-capacity and over-maximum bandwidth.

// File: rtl/slot_plan_pkg.sv
`timescale 1ns/1ps
// Shared types for the slot allocation engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package slot_plan_pkg;

    // Engine sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WALK,
        ST_EMIT,
        ST_FIN
    } plan_state_t;

endpackage

// File: rtl/slot_bw_admit.sv
`timescale 1ns/1ps
// Converts a bandwidth figure into a slot count against a region maximum,
// and checks whether that count fits beside the counts already presented.
// Assumes: purely combinational; bw_value above bw_max saturates to all ones.
module slot_bw_admit #(
    parameter int NUM_CLIENTS = 14,
    parameter int NUM_SLOTS   = 64,
    parameter int BW_W        = 32,
    parameter int CNTW        = 7
) (
    input  logic [NUM_CLIENTS*CNTW-1:0] req_counts,
    input  logic [BW_W-1:0]             bw_value,
    input  logic [BW_W-1:0]             bw_max,
    output logic [CNTW-1:0]             bw_slots,
    output logic                        admit_ok
);
    localparam int SUMW = CNTW + $clog2(NUM_CLIENTS) + 1;

    logic [BW_W-1:0] ratio;
    logic [BW_W-1:0] quot;
    logic [SUMW-1:0] total;

    // Slot count from bandwidth ratio, guarding both divisions.
    always_comb begin
        ratio = (bw_value == '0) ? '0 : (bw_max / bw_value);
        quot  = (ratio == '0) ? '0 : (BW_W'(NUM_SLOTS) / ratio);
        if (bw_value == '0)
            bw_slots = '0;
        else if (ratio == '0)
            bw_slots = '1;
        else
            bw_slots = CNTW'(quot);
    end

    // Sum of present requests plus the new one against capacity.
    always_comb begin
        total = '0;
        for (int c = 0; c < NUM_CLIENTS; c++)
            total = total + SUMW'(req_counts[c*CNTW +: CNTW]);
        admit_ok = (total + SUMW'(bw_slots)) <= SUMW'(NUM_SLOTS);
    end

endmodule

// File: rtl/slot_rr_pick.sv
`timescale 1ns/1ps
// Round-robin search: returns the first active client at or after the
// cursor, wrapping once; returns the cursor itself if none is active.
// Assumes: cursor < NUM_CLIENTS.
module slot_rr_pick #(
    parameter int NUM_CLIENTS = 14,
    parameter int CW          = 4
) (
    input  logic [NUM_CLIENTS-1:0] active,
    input  logic [CW-1:0]          cursor,
    output logic [CW-1:0]          pick
);
    // Scan offsets from far to near so the nearest active client wins.
    always_comb begin
        pick = cursor;
        for (int k = NUM_CLIENTS - 1; k >= 0; k--) begin
            if (active[(int'(cursor) + k) % NUM_CLIENTS])
                pick = CW'((int'(cursor) + k) % NUM_CLIENTS);
        end
    end

endmodule

// File: rtl/slot_table.sv
`timescale 1ns/1ps
// Working slot table: an occupancy bit and a client index per slot,
// one write port and one combinational read port.
// Assumes: clear and write are never requested in the same cycle.
module slot_table #(
    parameter int NUM_SLOTS = 64,
    parameter int CW        = 4,
    parameter int SW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [SW-1:0] rd_addr,
    output logic          rd_occ,
    output logic [CW-1:0] rd_who
);
    logic [NUM_SLOTS-1:0] occ;
    logic [CW-1:0]        who [NUM_SLOTS];

    // Occupancy: cleared on reset or run start, set on each placement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else if (clear)
            occ <= '0;
        else if (wr_en)
            occ[wr_addr] <= 1'b1;
    end

    // Client index storage, no reset needed since occupancy qualifies it.
    always_ff @(posedge clk) begin
        if (wr_en)
            who[wr_addr] <= wr_data;
    end

    // Read port.
    always_comb begin
        rd_occ = occ[rd_addr];
        rd_who = who[rd_addr];
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !occ[wr_addr]); // R2
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !wr_en); // R9

endmodule

// File: rtl/slot_plan_engine.sv
`timescale 1ns/1ps
// Slot allocation engine: samples per-client requests, active mask and a
// spare budget on start, places requesting clients at fixed intervals,
// grants spare slots to zero-request active clients, fills the rest in
// round-robin order and streams all slots, one per cycle, in slot order.
// Also exposes a bandwidth-to-slots helper with an admission check.
// Assumes: each request count is at most NUM_SLOTS.
module slot_plan_engine #(
    parameter  int NUM_CLIENTS = 14,
    parameter  int NUM_SLOTS   = 64,
    parameter  int BW_W        = 32,
    localparam int CW          = $clog2(NUM_CLIENTS),
    localparam int SW          = $clog2(NUM_SLOTS),
    localparam int CNTW        = $clog2(NUM_SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_CLIENTS*CNTW-1:0] req_counts,
    input  logic [NUM_CLIENTS-1:0]      active_mask,
    input  logic [CNTW-1:0]             spare_budget,
    input  logic [BW_W-1:0]             bw_value,
    input  logic [BW_W-1:0]             bw_max,
    output logic [CNTW-1:0]             bw_slots,
    output logic                        admit_ok,
    output logic                        wr_en,
    output logic [SW-1:0]               wr_slot,
    output logic [CW-1:0]               wr_client,
    output logic                        done
);
    import slot_plan_pkg::*;

    localparam int PW = SW + 1;
    localparam logic [CW-1:0] LAST_CLIENT = CW'(NUM_CLIENTS - 1);
    localparam logic [SW-1:0] LAST_SLOT   = SW'(NUM_SLOTS - 1);

    plan_state_t                 state;
    logic [NUM_CLIENTS*CNTW-1:0] req_q;
    logic [NUM_CLIENTS-1:0]      act_q;
    logic [CNTW-1:0]             budget_q;
    logic [CW-1:0]               cli_q;
    logic [PW-1:0]               pos_q;
    logic [CNTW-1:0]             interval_q;
    logic [SW-1:0]               emit_q;
    logic [CW-1:0]               rr_q;
    logic                        wr_en_q;
    logic [SW-1:0]               wr_slot_q;
    logic [CW-1:0]               wr_client_q;
    logic                        done_q;

    logic [CNTW-1:0] cur_req;
    logic [CNTW-1:0] cur_interval;
    logic            pos_end;
    logic            tbl_clear;
    logic            tbl_we;
    logic [SW-1:0]   tbl_rd_addr;
    logic            rd_occ;
    logic [CW-1:0]   rd_who;
    logic [CW-1:0]   pick;

    // Helper: bandwidth conversion and admission.
    slot_bw_admit #(
        .NUM_CLIENTS(NUM_CLIENTS), .NUM_SLOTS(NUM_SLOTS),
        .BW_W(BW_W), .CNTW(CNTW)
    ) i_bw_admit (
        .req_counts(req_counts), .bw_value(bw_value), .bw_max(bw_max),
        .bw_slots(bw_slots), .admit_ok(admit_ok)
    );

    // Current client's request and its placement interval.
    always_comb begin
        cur_req      = req_q[cli_q*CNTW +: CNTW];
        cur_interval = (cur_req == '0) ? CNTW'(NUM_SLOTS)
                                       : (CNTW'(NUM_SLOTS) / cur_req);
        pos_end      = pos_q >= PW'(NUM_SLOTS);
    end

    // Table access steering: placement walk or emission scan.
    always_comb begin
        tbl_clear   = (state == ST_IDLE) && start;
        tbl_we      = (state == ST_WALK) && !pos_end && !rd_occ;
        tbl_rd_addr = (state == ST_WALK) ? pos_q[SW-1:0] : emit_q;
    end

    slot_table #(.NUM_SLOTS(NUM_SLOTS), .CW(CW), .SW(SW)) i_table (
        .clk(clk), .rst_n(rst_n), .clear(tbl_clear),
        .wr_en(tbl_we), .wr_addr(pos_q[SW-1:0]), .wr_data(cli_q),
        .rd_addr(tbl_rd_addr), .rd_occ(rd_occ), .rd_who(rd_who)
    );

    slot_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS), .CW(CW)) i_rr_pick (
        .active(act_q), .cursor(rr_q), .pick(pick)
    );

    // Sequencer: sample, place, fill and emit, then pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            act_q       <= '0;
            budget_q    <= '0;
            cli_q       <= '0;
            pos_q       <= '0;
            interval_q  <= '0;
            emit_q      <= '0;
            rr_q        <= '0;
            wr_en_q     <= 1'b0;
            wr_slot_q   <= '0;
            wr_client_q <= '0;
            done_q      <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            done_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q    <= req_counts;
                        act_q    <= active_mask;
                        budget_q <= spare_budget;
                        cli_q    <= '0;
                        state    <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    if (cur_req != '0) begin
                        interval_q <= cur_interval;
                        pos_q      <= '0;
                        state      <= ST_WALK;
                    end else if (act_q[cli_q] && budget_q != '0) begin
                        budget_q   <= budget_q - 1'b1;
                        interval_q <= CNTW'(NUM_SLOTS);
                        pos_q      <= '0;
                        state      <= ST_WALK;
                    end else if (cli_q == LAST_CLIENT) begin
                        emit_q <= '0;
                        rr_q   <= '0;
                        state  <= ST_EMIT;
                    end else begin
                        cli_q <= cli_q + 1'b1;
                    end
                end
                ST_WALK: begin
                    if (pos_end) begin
                        if (cli_q == LAST_CLIENT) begin
                            emit_q <= '0;
                            rr_q   <= '0;
                            state  <= ST_EMIT;
                        end else begin
                            cli_q <= cli_q + 1'b1;
                            state <= ST_SELECT;
                        end
                    end else if (rd_occ) begin
                        pos_q <= pos_q + 1'b1;
                    end else begin
                        pos_q <= pos_q + PW'(interval_q);
                    end
                end
                ST_EMIT: begin
                    wr_en_q   <= 1'b1;
                    wr_slot_q <= emit_q;
                    if (rd_occ) begin
                        wr_client_q <= rd_who;
                    end else begin
                        wr_client_q <= pick;
                        rr_q <= (pick == LAST_CLIENT) ? '0 : pick + 1'b1;
                    end
                    if (emit_q == LAST_SLOT)
                        state <= ST_FIN;
                    else
                        emit_q <= emit_q + 1'b1;
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        wr_en     = wr_en_q;
        wr_slot   = wr_slot_q;
        wr_client = wr_client_q;
        done      = done_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_q && $past(wr_en_q)) |-> (wr_slot_q == $past(wr_slot_q) + 1'b1)); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(wr_en_q) && $past(wr_slot_q) == LAST_SLOT)); // R6
    AST_CLIENT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> ({1'b0, wr_client_q} < (CW+1)'(NUM_CLIENTS))); // R2
    AST_FILL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && !rd_occ && (act_q != '0)) |-> act_q[pick]); // R4
    AST_BUDGET_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (budget_q <= $past(budget_q))); // R3

endmodule

// File: tb/test_slot_plan_engine.sv
`timescale 1ns/1ps
module test_slot_plan_engine;
    localparam int NC = 14;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [97:0] req_counts = '0;
    logic [13:0] active_mask = '0;
    logic [6:0]  spare_budget = '0;
    logic [31:0] bw_value = '0;
    logic [31:0] bw_max = '0;
    logic [6:0]  bw_slots;
    logic        admit_ok;
    logic        wr_en;
    logic [5:0]  wr_slot;
    logic [3:0]  wr_client;
    logic        done;

    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;
    int m_tab [NS];
    int got [NS];

    // Conversion/admission vectors; client 0 presents 60 slots meanwhile.
    localparam int NV = 7;
    localparam int V_BW  [NV] = '{0, 25, 6, 7, 10, 200, 100};
    localparam int V_SL  [NV] = '{0, 16, 4, 4, 6, 127, 64};
    localparam int V_OK  [NV] = '{1, 0, 1, 1, 0, 0, 0};

    slot_plan_engine i_slot_plan_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .req_counts(req_counts),
        .active_mask(active_mask), .spare_budget(spare_budget),
        .bw_value(bw_value), .bw_max(bw_max), .bw_slots(bw_slots),
        .admit_ok(admit_ok), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_client(wr_client), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    // Independent model of the two-pass allocation.
    task automatic build_model(input logic [97:0] rq, input logic [13:0] act, input int bud);
        int b = bud;
        int cur = 0;
        for (int s = 0; s < NS; s++) m_tab[s] = -1;
        for (int c = 0; c < NC; c++) begin
            int n = int'(rq[c*7 +: 7]);
            int iv;
            int p = 0;
            if (n == 0) begin
                if (!act[c] || b <= 0) continue;
                b--;
                iv = NS;
            end else iv = NS / n;
            while (p < NS) begin
                if (m_tab[p] >= 0) p++;
                else begin m_tab[p] = c; p += iv; end
            end
        end
        for (int s = 0; s < NS; s++) begin
            if (m_tab[s] < 0) begin
                int first = cur;
                while (!act[cur]) begin
                    cur = (cur + 1) % NC;
                    if (cur == first) break;
                end
                m_tab[s] = cur;
                cur = (cur + 1) % NC;
            end
        end
    endtask

    // One run: start, collect writes, compare with the model.
    task automatic run_engine(input logic [97:0] rq, input logic [13:0] act,
                              input int bud, input int poke_at, input string req);
        int nwr = 0;
        int cyc = 0;
        int bad = 0;
        int first_bad = -1;
        bit order_ok = 1'b1;
        bit seen_done = 1'b0;
        build_model(rq, act, bud);
        for (int s = 0; s < NS; s++) got[s] = -1;
        @(negedge clk);
        req_counts = rq; active_mask = act; spare_budget = 7'(bud); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && cyc < 4000) begin
            if (cyc == poke_at) begin
                start = 1'b1; req_counts = '0; active_mask = 14'h0001; spare_budget = '0;
            end else start = 1'b0;
            if (wr_en) begin
                if (int'(wr_slot) != nwr) order_ok = 1'b0;
                got[int'(wr_slot)] = int'(wr_client);
                nwr++;
            end
            if (done) seen_done = 1'b1;
            else begin @(negedge clk); cyc++; end
        end
        start = 1'b0;
        check(seen_done && order_ok && nwr == NS, "R6 write count/order", nwr, NS);
        for (int s = 0; s < NS; s++)
            if (got[s] != m_tab[s]) begin
                bad++;
                if (first_bad < 0) first_bad = s;
            end
        if (first_bad >= 0)
            check(1'b0, req, got[first_bad], m_tab[first_bad]);
        else
            check(1'b1, req, 0, 0);
        @(negedge clk);
        check(!done && !wr_en, "R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        logic [97:0] rq;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!wr_en && !done, "R1 reset outputs", int'(wr_en) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en && !done, "R1 after reset", int'(wr_en) + int'(done), 0);

        // R7/R8: vector table for the conversion helper
        req_counts = '0;
        req_counts[6:0] = 7'd60;
        bw_max = 32'd100;
        for (int v = 0; v < NV; v++) begin
            bw_value = 32'(V_BW[v]);
            #1;
            check(int'(bw_slots) == V_SL[v], "R7 bw_slots", int'(bw_slots), V_SL[v]);
            check(int'(admit_ok) == V_OK[v], "R8 admit_ok", int'(admit_ok), V_OK[v]);
            @(negedge clk);
        end
        req_counts = '0; bw_value = 32'd100;
        #1;
        check(admit_ok == 1'b1 && bw_slots == 7'd64, "R8 exact fit", int'(bw_slots), 64);

        // R2: one full-rate client covers every slot
        rq = '0; rq[6:0] = 7'd64;
        run_engine(rq, 14'h0000, 0, -1, "R2 full-rate client");
        check(got[37] == 0, "R2 slot 37", got[37], 0);

        // R2/R5: colliding intervals, nothing active
        rq = '0; rq[6:0] = 7'd3; rq[13:7] = 7'd5;
        run_engine(rq, 14'h0000, 0, -1, "R2 colliding intervals");
        check(got[63] == 0, "R2 client0 at 63", got[63], 0);
        check(got[1] == 1, "R2 skip occupied", got[1], 1);
        check(got[13] == 1, "R2 interval 12", got[13], 1);
        check(got[2] == 0 && got[3] == 1, "R5 cursor fallback", got[3], 1);

        // R4: clients 10 and 11 active with no requests
        run_engine('0, 14'h0C00, 0, -1, "R4 round robin");
        check(got[0] == 10 && got[1] == 11 && got[2] == 10, "R4 alternation", got[1], 11);

        // R3: spare budget for zero-request active clients 2 and 5
        rq = '0; rq[6:0] = 7'd32;
        run_engine(rq, 14'h0024, 1, -1, "R3 budget 1");
        check(got[1] == 2 && got[3] == 2 && got[5] == 5, "R3 budget 1 slots", got[5], 5);
        run_engine(rq, 14'h0024, 2, -1, "R3 budget 2");
        check(got[3] == 5, "R3 second spare", got[3], 5);
        run_engine(rq, 14'h0024, 0, -1, "R3 budget 0");
        check(got[1] == 2 && got[3] == 5, "R3 no spare", got[3], 5);
        run_engine(rq, 14'h0004, 1, -1, "R3 inactive zero request");

        // R9: start with other inputs mid-run is ignored
        rq = '0; rq[13:7] = 7'd7; rq[27:21] = 7'd9;
        run_engine(rq, 14'h2102, 3, 5, "R9 start while busy");
        begin
            int extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (wr_en || done) extra++;
            end
            check(extra == 0, "R9 no second run", extra, 0);
        end

        // R2/R3/R4: random request sets against the model
        void'($urandom(32'd11));
        for (int i = 0; i < 20; i++) begin
            int remaining = NS;
            int bud;
            logic [13:0] act;
            rq = '0;
            for (int c = 0; c < NC; c++) begin
                int r = 0;
                if (($urandom % 2) == 1 && remaining > 0)
                    r = 1 + int'($urandom % 32'(remaining < 16 ? remaining : 16));
                rq[c*7 +: 7] = 7'(r);
                remaining -= r;
            end
            act = 14'($urandom);
            bud = (i % 3 == 0) ? int'($urandom % 5) : remaining;
            run_engine(rq, act, bud, -1, "R2 R3 R4 random set");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule